// File: doc/BRIEF.md
# Low-Power Operating Mode Controller

This block sits next to a small 8-bit processor core and moves it between three operating modes. In the run mode the core, the oscillator and the peripheral clocks are all active. A sleep-instruction strobe from the decoder starts a halt. The mode-select bit in a local control register picks which kind of halt follows. In the light halt the core stops, while the oscillator and the peripherals keep running. In the deep halt the core stops and the oscillator and peripheral clocks are switched off.

Each halt has its own wake source. Any pending interrupt ends the light halt. Only the active-low wake pin ends the deep halt. When the block leaves a halt, it sends the core a one-cycle indication. That indication either tells the core to take the interrupt vector first, or to resume at the instruction after the sleep instruction. The choice depends on the global interrupt enable.

When the deep halt ends, the oscillator is re-enabled at once. The core stays halted for a parameterised settling window before it runs again. A synchronous active-low reset returns the block to the run mode from any state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, cpu_halt is 0, osc_en is 1, periph_clk_en is 1, wake_vector and wake_resume are 0, and the control register reads 8'h00.
- R2: The control register is written from reg_wr_data on a clock edge with reg_wr_en high. The prescaler field is bits [2:0] and appears on prescale_sel. The auxiliary flag is bit 3. The mode-select bit is bit 4. Bits [7:5] always read 0.
- R3: A sleep strobe with mode-select 0 and no pending interrupt enters the light halt on that clock edge: cpu_halt is 1, osc_en is 1 and periph_clk_en is 1.
- R4: A sleep strobe with mode-select 1 and the wake pin high enters the deep halt on that clock edge: cpu_halt is 1, osc_en is 0 and periph_clk_en is 0.
- R5: In the light halt, an interrupt raised before clock edge k releases cpu_halt at edge k+2, after two synchroniser flops. When gie is 1, wake_vector pulses in that same cycle.
- R6: When the light halt ends with gie at 0, wake_resume pulses and wake_vector stays 0.
- R7: A pending interrupt has no effect in the deep halt: osc_en stays 0 and cpu_halt stays 1.
- R8: A low level on wake_n in the deep halt sets osc_en at edge k+2, after synchronisation. cpu_halt then stays 1 for STAB_CYCLES more cycles. It then falls together with a wake_resume pulse.
- R9: A wake condition that is already synchronised when the sleep strobe arrives causes no halt cycle. The strobe edge itself produces the wake pulse: wake_vector or wake_resume for the light halt, depending on gie, and wake_resume for the deep halt.
- R10: A low rst_n at a clock edge in any mode returns the outputs to the R1 values at that edge and clears the control register.
- R11: wake_vector and wake_resume are never high together, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of the controller |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_op | input | 1 | One-cycle strobe for a decoded sleep instruction |
| reg_wr_en | input | 1 | Write enable for the control register |
| reg_wr_data | input | 8 | Write data for the control register |
| reg_rd_data | output | 8 | Readback of the control register |
| prescale_sel | output | 3 | Prescaler select field |
| irq_pending | input | 1 | Any interrupt source pending (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| wake_n | input | 1 | Active-low wake pin (asynchronous) |
| cpu_halt | output | 1 | Holds the core stopped |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| wake_vector | output | 1 | One-cycle pulse: take the interrupt vector on wake |
| wake_resume | output | 1 | One-cycle pulse: resume at the next instruction on wake |

## Verification
The hardest case to reach is the one where the wake condition is already present when the sleep strobe arrives. Here the block must skip the halt altogether and still produce the right wake pulse. The stimulus raises the interrupt or pulls the wake pin low, then waits until both synchroniser flops have settled before it issues the strobe. The expected pulse is then checked on the cycle right after the strobe edge.

The deep-halt settling window is checked at its edges. The bench samples cpu_halt on the last halted cycle and again on the first running cycle.

// File: rtl/pwr_mode_pkg.sv
// Package: shared state encoding and control-register layout for the
// low-power mode controller. Assumes an 8-bit control register.
package pwr_mode_pkg;
    localparam int CTL_W       = 8;
    localparam int PS_W        = 3;
    localparam int PS_LSB      = 0;
    localparam int AUX_BIT     = 3;
    localparam int SEL_BIT     = 4;
    localparam int USED_W      = SEL_BIT + 1;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_SLEEP  = 2'd2,
        MODE_SETTLE = 2'd3
    } pm_state_e;
endpackage

// File: rtl/pm_sync.sv
// Module: pm_sync
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is an independent level signal; RST_VAL gives the
// value every stage takes under the synchronous active-low reset.
module pm_sync #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic s1_q, s2_q;
            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1_q <= RST_VAL[i];
                    s2_q <= RST_VAL[i];
                end else begin
                    s1_q <= d_async[i];
                    s2_q <= s1_q;
                end
            end
            assign q_sync[i] = s2_q;
        end
    endgenerate
endmodule

// File: rtl/pm_ctl_reg.sv
// Module: pm_ctl_reg
// Control register holding the prescaler field, an auxiliary flag and the
// halt-mode select bit. Assumes single-cycle writes; unused bits read 0.
module pm_ctl_reg
    import pwr_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    output logic [PS_W-1:0]  prescale,
    output logic             mode_sel
);
    logic [USED_W-1:0] fields_q;
    logic              unused_hi;

    // Store only the implemented bits; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     fields_q <= '0;
        else if (wr_en) fields_q <= wr_data[USED_W-1:0];
    end

    assign unused_hi = ^wr_data[CTL_W-1:USED_W];
    assign rd_data   = {{(CTL_W-USED_W){1'b0}}, fields_q};
    assign prescale  = fields_q[PS_LSB +: PS_W];
    assign mode_sel  = fields_q[SEL_BIT];
endmodule

// File: rtl/pm_mode_fsm.sv
// Module: pm_mode_fsm
// Mode sequencer: run, light halt, deep halt, and the settling window
// after a deep halt. Assumes irq_s and wake_s are already synchronised
// and that sleep_op is a one-cycle strobe that arrives only while running.
module pm_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int STAB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_op,
    input  logic mode_sel,
    input  logic irq_s,
    input  logic wake_s,
    input  logic gie,
    output logic cpu_halt,
    output logic osc_en,
    output logic periph_clk_en,
    output logic wake_vector,
    output logic wake_resume
);
    localparam int CW = $clog2(STAB_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(STAB_CYCLES - 1);

    pm_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          vec_q, vec_d, res_q, res_d;

    // Next-state, settle-counter and wake-pulse decision.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        vec_d   = 1'b0;
        res_d   = 1'b0;
        unique case (state_q)
            MODE_RUN: begin
                if (sleep_op) begin
                    if (!mode_sel) begin
                        if (irq_s) begin
                            vec_d = gie;
                            res_d = !gie;
                        end else begin
                            state_d = MODE_IDLE;
                        end
                    end else if (wake_s) begin
                        res_d = 1'b1;
                    end else begin
                        state_d = MODE_SLEEP;
                    end
                end
            end
            MODE_IDLE: begin
                if (irq_s) begin
                    state_d = MODE_RUN;
                    vec_d   = gie;
                    res_d   = !gie;
                end
            end
            MODE_SLEEP: begin
                if (wake_s) begin
                    state_d = MODE_SETTLE;
                    cnt_d   = CNT_LOAD;
                end
            end
            MODE_SETTLE: begin
                if (cnt_q == '0) begin
                    state_d = MODE_RUN;
                    res_d   = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = MODE_RUN;
        endcase
    end

    // State, counter and pulse registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_RUN;
            cnt_q   <= '0;
            vec_q   <= 1'b0;
            res_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            vec_q   <= vec_d;
            res_q   <= res_d;
        end
    end

    assign cpu_halt      = (state_q != MODE_RUN);
    assign osc_en        = (state_q != MODE_SLEEP);
    assign periph_clk_en = (state_q == MODE_RUN) || (state_q == MODE_IDLE);
    assign wake_vector   = vec_q;
    assign wake_resume   = res_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Low-power operating mode controller: control register, input
// synchronisers and mode sequencer. Assumes clk keeps running as the
// controller's reference while the core oscillator is disabled.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int STAB_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_op,
    input  logic             reg_wr_en,
    input  logic [CTL_W-1:0] reg_wr_data,
    output logic [CTL_W-1:0] reg_rd_data,
    output logic [PS_W-1:0]  prescale_sel,
    input  logic             irq_pending,
    input  logic             gie,
    input  logic             wake_n,
    output logic             cpu_halt,
    output logic             osc_en,
    output logic             periph_clk_en,
    output logic             wake_vector,
    output logic             wake_resume
);
    logic       mode_sel;
    logic [1:0] sync_q;

    pm_ctl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .rd_data  (reg_rd_data),
        .prescale (prescale_sel),
        .mode_sel (mode_sel)
    );

    // bit 0: interrupt pending, bit 1: wake request (pin inverted).
    pm_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({~wake_n, irq_pending}),
        .q_sync  (sync_q)
    );

    pm_mode_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep_op      (sleep_op),
        .mode_sel      (mode_sel),
        .irq_s         (sync_q[0]),
        .wake_s        (sync_q[1]),
        .gie           (gie),
        .cpu_halt      (cpu_halt),
        .osc_en        (osc_en),
        .periph_clk_en (periph_clk_en),
        .wake_vector   (wake_vector),
        .wake_resume   (wake_resume)
    );
endmodule

// File: rtl/pwr_mode_ctrl_checker.sv
// Module: pwr_mode_ctrl_checker
// Port-level properties of the mode controller, bound to the top module.
module pwr_mode_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rd_data,
    input logic       cpu_halt,
    input logic       osc_en,
    input logic       periph_clk_en,
    input logic       wake_vector,
    input logic       wake_resume
);
    logic rst_seen_q;

    // Remember that reset was low at the previous edge.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R10: one edge after reset, the outputs show the run mode.
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            a_r10_reset_run: assert (!cpu_halt && osc_en && periph_clk_en && reg_rd_data == 8'h00)
                else $error("reset did not return to run mode");
        end
    end

    // R4: a stopped oscillator always goes with a halted core and gated peripherals.
    a_r4_deep_halt_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (cpu_halt && !periph_clk_en));

    // R8: leaving the deep halt always passes through a halted settling cycle.
    a_r8_settle_first: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> (!osc_en || cpu_halt));

    // R5: a wake pulse only appears while the core runs.
    a_r5_pulse_running: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_vector || wake_resume) |-> !cpu_halt);

    // R11: the two wake indications are mutually exclusive.
    a_r11_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_vector && wake_resume));

    // R11: each wake indication lasts a single cycle.
    a_r11_vector_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_vector |=> !wake_vector);
    a_r11_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_resume |=> !wake_resume);

    // R2: the unimplemented register bits always read 0.
    a_r2_hi_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[7:5] == 3'b000);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_rd_data   (reg_rd_data),
    .cpu_halt      (cpu_halt),
    .osc_en        (osc_en),
    .periph_clk_en (periph_clk_en),
    .wake_vector   (wake_vector),
    .wake_resume   (wake_resume)
);

// File: tb/pwr_mode_ctrl_test.sv
// Directed bench for pwr_mode_ctrl: one task per scenario.
module pwr_mode_ctrl_test;
    localparam int STAB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_op = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic [2:0] prescale_sel;
    logic       irq_pending = 1'b0;
    logic       gie = 1'b0;
    logic       wake_n = 1'b1;
    logic       cpu_halt, osc_en, periph_clk_en, wake_vector, wake_resume;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(.STAB_CYCLES(STAB)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_op(sleep_op),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .prescale_sel(prescale_sel),
        .irq_pending(irq_pending), .gie(gie), .wake_n(wake_n),
        .cpu_halt(cpu_halt), .osc_en(osc_en), .periph_clk_en(periph_clk_en),
        .wake_vector(wake_vector), .wake_resume(wake_resume)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
        end
    endtask

    // Pack the visible outputs as {halt, osc, periph, vector, resume}.
    function automatic int outs();
        return {cpu_halt, osc_en, periph_clk_en, wake_vector, wake_resume};
    endfunction

    task automatic expect_outs(input string req, input int exp);
        check(outs() == exp, req, "outputs", outs(), exp);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] v);
        reg_wr_en = 1'b1; reg_wr_data = v;
        step(1);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_op = 1'b1;
        step(1);
        sleep_op = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        expect_outs("R1", 5'b01100);
        check(reg_rd_data == 8'h00, "R1", "register", reg_rd_data, 0);
    endtask

    task automatic t_register();
        write_reg(8'hFF);
        check(reg_rd_data == 8'h1F, "R2", "readback ff", reg_rd_data, 8'h1F);
        check(prescale_sel == 3'b111, "R2", "prescale", prescale_sel, 7);
        write_reg(8'hA5);
        check(reg_rd_data == 8'h05, "R2", "readback a5", reg_rd_data, 8'h05);
        check(prescale_sel == 3'b101, "R2", "prescale", prescale_sel, 5);
        write_reg(8'h00);
    endtask

    task automatic t_idle(input bit g);
        write_reg(8'h00);
        gie = g;
        pulse_sleep();
        expect_outs("R3", 5'b11100);
        irq_pending = 1'b1;
        step(2);
        expect_outs("R5", 5'b11100);
        step(1);
        if (g) expect_outs("R5", 5'b01110);
        else   expect_outs("R6", 5'b01101);
        step(1);
        expect_outs("R11", 5'b01100);
        irq_pending = 1'b0;
        step(3);
    endtask

    task automatic t_sleep();
        write_reg(8'h10);
        pulse_sleep();
        expect_outs("R4", 5'b10000);
        irq_pending = 1'b1;
        step(6);
        expect_outs("R7", 5'b10000);
        irq_pending = 1'b0;
        wake_n = 1'b0;
        step(2);
        expect_outs("R8", 5'b10000);
        step(1);
        expect_outs("R8", 5'b11000);
        wake_n = 1'b1;
        step(STAB - 1);
        expect_outs("R8", 5'b11000);
        step(1);
        expect_outs("R8", 5'b01101);
        step(1);
        expect_outs("R11", 5'b01100);
        step(3);
    endtask

    task automatic t_early_wake();
        write_reg(8'h00);
        gie = 1'b1;
        irq_pending = 1'b1;
        step(3);
        pulse_sleep();
        expect_outs("R9", 5'b01110);
        irq_pending = 1'b0;
        step(3);
        write_reg(8'h10);
        wake_n = 1'b0;
        step(3);
        pulse_sleep();
        expect_outs("R9", 5'b01101);
        wake_n = 1'b1;
        step(3);
    endtask

    task automatic t_reset_from_sleep();
        write_reg(8'h13);
        pulse_sleep();
        expect_outs("R10", 5'b10000);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        expect_outs("R10", 5'b01100);
        check(reg_rd_data == 8'h00, "R10", "register", reg_rd_data, 0);
    endtask

    initial begin
        fork
            begin
                step(1);
                t_reset();
                t_register();
                t_idle(1'b1);
                t_idle(1'b0);
                t_sleep();
                t_early_wake();
                t_reset_from_sleep();
            end
            begin
                step(20000);
                check(1'b0, "WDOG", "watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule